// File: doc/BRIEF.md
# Programming-Mode Address Counter and Memory Map

This block models the target side of a small microcontroller's programming mode. An external programmer steers a one-way address counter through a 1024-word space. The lower half holds 512 user words. The upper half holds four identification words, one backup calibration word and the configuration word, and every other address there is empty. A host writes a 14-bit word into a staging latch. A program strobe then merges the staged word into the addressed location by clearing bits; it never sets them. A read port returns the addressed word, widened to 14 bits. While the protect bit of the configuration word is low, the read port hides most of the user space.

Entering the mode points the counter at the configuration word. That word stays reachable only until the first increment, so it cannot be reached again without leaving and re-entering the mode. A bulk erase strobe clears state to all ones. How much it clears depends on where the counter points: user space or the open configuration word selects a main erase, and the first identification word selects a full erase. Serial framing and host-side sequencing belong to other blocks.

Top module: `pgm_mode_map`

## Requirements
- R1: After reset every stored word (user, identification, backup and configuration) is 0xFFF, the counter is 0x3FF, the staging latch is 0xFFF and the configuration word is closed.
- R2: A cycle with `mode_en` high that follows a cycle with it low (or reset) is an entry cycle. It sets the counter to 0x3FF and opens the configuration word. Strobes in an entry cycle, and all strobes while `mode_en` is low, have no effect.
- R3: `inc` adds one to the counter modulo 1024, so 0x1FF steps to 0x200 and 0x3FF steps to 0x000. No other input moves the counter, and it never counts down.
- R4: Any increment closes the configuration word until the next entry. While it is closed, address 0x3FF reads 0xFFF and ignores program and erase.
- R5: Addresses 0x000-0x1FF are user words, 0x200-0x203 are identification words 0 to 3, and 0x204 is the backup calibration word. Addresses 0x205-0x3FF, other than the open configuration word, read 0xFFF and ignore writes.
- R6: Bits 13:12 of `rd_data` are always 0. Bits 13:12 of `load_data` are ignored.
- R7: `load_vld` copies `load_data[11:0]` into the staging latch. `prog` replaces the addressed word with the word ANDed with the latch, using the latch value held before a `load_vld` in the same cycle.
- R8: Configuration bit 3 is the protect bit, and protection is on when it is 0. With protection on, reads of 0x040-0x1FE return 0, while 0x000-0x03F, 0x1FF, the identification words, the backup word and the configuration word read unmasked. Identification, backup and configuration words stay programmable while protection is on.
- R9: `erase` with the counter in user space, or on the open configuration word, sets all user words and the configuration word to 0xFFF and keeps the identification and backup words.
- R10: `erase` with the counter at 0x200 sets every stored word to 0xFFF, including the identification and backup words.
- R11: `erase` at any other counter position has no effect. When `erase` and `prog` fall in the same cycle, the erase is carried out and the program is dropped. When `inc` falls in the same cycle as `prog` or `erase`, the operation acts at the old address and the counter then steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_en | input | 1 | Programming mode enable; a rise starts an entry |
| inc | input | 1 | Increment the address counter |
| load_vld | input | 1 | Stage `load_data` in the latch |
| load_data | input | 14 | Word to stage; the top two bits are ignored |
| prog | input | 1 | Program the addressed word from the latch |
| erase | input | 1 | Bulk erase, with a scope set by the counter position |
| pc | output | 10 | Current address counter |
| rd_data | output | 14 | Word at the counter after masking |

## Verification
The bench exercises operations that land in the same cycle, and the one most exercised is programming together with an increment. The full write sweep gives every address a load followed by a single cycle that carries both `prog` and `inc`. A later read sweep must then find each stored pattern at the address the counter held before it stepped, with the counter one higher. Erase is also paired with program at a user address, where the result must read 0xFFF and not the staged latch value. Erase is paired with an increment at 0x1FF: the counter must land on 0x200 while the identification words survive, which shows the main erase, not the full erase, was taken.

// File: rtl/pgm_map_pkg.sv
// Shared types for the programming-mode memory map.
// Assumes: consumers import the package or use scoped names.
package pgm_map_pkg;

    // Which storage class the current counter value selects.
    typedef enum logic [2:0] {
        RG_USER = 3'd0,
        RG_UID  = 3'd1,
        RG_BKUP = 3'd2,
        RG_CFGW = 3'd3,
        RG_VOID = 3'd4
    } region_e;

    // Scope of a bulk erase decided from the counter position.
    typedef enum logic [1:0] {
        ER_NONE = 2'd0,
        ER_MAIN = 2'd1,
        ER_FULL = 2'd2
    } erase_e;

endpackage

// File: rtl/pgm_addr_ctr.sv
// One-way address counter with a mode-entry detector and a
// configuration-word gate.
// Assumes: mode_en is synchronous to clk. The counter only counts
// up and wraps naturally at its width.
module pgm_addr_ctr #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic              inc,
    output logic              entry,
    output logic              active,
    output logic              cfg_open,
    output logic [ADDR_W-1:0] pc
);

    logic mode_q;

    // Entry is the first cycle with the mode on; active is every later cycle.
    assign entry  = mode_en & ~mode_q;
    assign active = mode_en & mode_q;

    // Track mode, load the counter on entry, step it on increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            pc       <= '1;
            cfg_open <= 1'b0;
        end else begin
            mode_q <= mode_en;
            if (entry) begin
                pc       <= '1;
                cfg_open <= 1'b1;
            end else if (!mode_en) begin
                cfg_open <= 1'b0;
            end else if (inc) begin
                pc       <= pc + 1'b1;
                cfg_open <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pgm_region_dec.sv
// Decodes the counter into a storage class and an index within it.
// Assumes: ID_COUNT is a power of two, and the identification words
// start at the bottom of the upper half of the space.
module pgm_region_dec
    import pgm_map_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int ID_COUNT = 4,
    localparam int UI_W    = ADDR_W - 1,
    localparam int IDX_W   = $clog2(ID_COUNT)
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic              cfg_open,
    output region_e           region,
    output logic [UI_W-1:0]   uidx,
    output logic [IDX_W-1:0]  iidx
);

    localparam int USER_WORDS = 1 << UI_W;
    localparam logic [ADDR_W-1:0] CFG_BASE  = ADDR_W'(USER_WORDS);
    localparam logic [ADDR_W-1:0] BKUP_ADDR = ADDR_W'(USER_WORDS + ID_COUNT);

    assign uidx = pc[UI_W-1:0];
    assign iidx = pc[IDX_W-1:0];

    // Classify the address; the top slot is live only while the gate is open.
    always_comb begin
        if (pc < CFG_BASE)
            region = RG_USER;
        else if (pc < BKUP_ADDR)
            region = RG_UID;
        else if (pc == BKUP_ADDR)
            region = RG_BKUP;
        else if ((pc == '1) && cfg_open)
            region = RG_CFGW;
        else
            region = RG_VOID;
    end

endmodule

// File: rtl/pgm_store.sv
// Holds the user array, identification words, backup word and
// configuration word. Performs bit-clearing writes and scoped erases,
// and returns the word of the selected class.
// Assumes: erase_kind and wr_en are never both active (the caller
// resolves that), and the region and indices reflect the current counter.
module pgm_store
    import pgm_map_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int WORD_W   = 12,
    parameter int ID_COUNT = 4,
    parameter int PROT_BIT = 3,
    localparam int UI_W    = ADDR_W - 1,
    localparam int IDX_W   = $clog2(ID_COUNT),
    localparam int USER_WORDS = 1 << UI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  region_e           region,
    input  logic [UI_W-1:0]   uidx,
    input  logic [IDX_W-1:0]  iidx,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  erase_e            erase_kind,
    output logic [WORD_W-1:0] rd_word,
    output logic              prot_on
);

    logic [WORD_W-1:0] user_q [USER_WORDS];
    logic [WORD_W-1:0] uid_q  [ID_COUNT];
    logic [WORD_W-1:0] bkup_q;
    logic [WORD_W-1:0] cfgw_q;

    // User array: cleared by either erase scope, AND-written when selected.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_kind != ER_NONE) begin
            for (int k = 0; k < USER_WORDS; k++) user_q[k] <= '1;
        end else if (wr_en && region == RG_USER) begin
            user_q[uidx] <= user_q[uidx] & wr_word;
        end
    end

    // One register per identification word; only a full erase clears them.
    for (genvar g = 0; g < ID_COUNT; g++) begin : g_uid
        always_ff @(posedge clk) begin
            if (!rst_n || erase_kind == ER_FULL)
                uid_q[g] <= '1;
            else if (wr_en && region == RG_UID && iidx == IDX_W'(g))
                uid_q[g] <= uid_q[g] & wr_word;
        end
    end

    // Backup calibration word; only a full erase clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_kind == ER_FULL)
            bkup_q <= '1;
        else if (wr_en && region == RG_BKUP)
            bkup_q <= bkup_q & wr_word;
    end

    // Configuration word; cleared by either erase scope.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_kind != ER_NONE)
            cfgw_q <= '1;
        else if (wr_en && region == RG_CFGW)
            cfgw_q <= cfgw_q & wr_word;
    end

    assign prot_on = ~cfgw_q[PROT_BIT];

    // Return the word of the selected class; empty slots read all ones.
    always_comb begin
        unique case (region)
            RG_USER: rd_word = user_q[uidx];
            RG_UID:  rd_word = uid_q[iidx];
            RG_BKUP: rd_word = bkup_q;
            RG_CFGW: rd_word = cfgw_q;
            default: rd_word = '1;
        endcase
    end

endmodule

// File: rtl/pgm_read_mask.sv
// Applies read protection to the protected part of user space and
// widens the stored word to the bus width with zero top bits.
// Assumes: the last user word and the words below PROT_FLOOR are
// always visible.
module pgm_read_mask
    import pgm_map_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int WORD_W     = 12,
    parameter int BUS_W      = 14,
    parameter int PROT_FLOOR = 64,
    localparam int UI_W      = ADDR_W - 1
) (
    input  region_e           region,
    input  logic [UI_W-1:0]   uidx,
    input  logic [WORD_W-1:0] word,
    input  logic              prot_on,
    output logic [BUS_W-1:0]  rd_data
);

    logic hide;

    // Protected window: user words from the floor up to one below the last.
    assign hide = prot_on && (region == RG_USER)
               && (uidx >= UI_W'(PROT_FLOOR)) && (uidx != '1);

    // Zero the word when hidden, otherwise extend it with zero top bits.
    always_comb begin
        rd_data = '0;
        if (!hide) rd_data[WORD_W-1:0] = word;
    end

endmodule

// File: rtl/pgm_mode_map.sv
// Top of the programming-mode memory map. It joins the counter, the
// region decoder, the storage and the read mask, stages load words,
// and settles the precedence between strobes that fall in one cycle.
// Assumes: all inputs are synchronous to clk, and strobes are level
// and act once for each cycle they are high.
module pgm_mode_map
    import pgm_map_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int WORD_W     = 12,
    parameter int BUS_W      = 14,
    parameter int ID_COUNT   = 4,
    parameter int PROT_FLOOR = 64,
    parameter int PROT_BIT   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic              inc,
    input  logic              load_vld,
    input  logic [BUS_W-1:0]  load_data,
    input  logic              prog,
    input  logic              erase,
    output logic [ADDR_W-1:0] pc,
    output logic [BUS_W-1:0]  rd_data
);

    localparam int UI_W  = ADDR_W - 1;
    localparam int IDX_W = $clog2(ID_COUNT);
    localparam logic [ADDR_W-1:0] CFG_BASE = ADDR_W'(1 << UI_W);

    logic              entry;
    logic              active;
    logic              cfg_open;
    region_e           region;
    logic [UI_W-1:0]   uidx;
    logic [IDX_W-1:0]  iidx;
    logic [WORD_W-1:0] latch_q;
    logic              wr_en;
    erase_e            erase_kind;
    logic [WORD_W-1:0] stored_word;
    logic              prot_on;
    logic              unused_hi;

    assign unused_hi = ^load_data[BUS_W-1:WORD_W];

    pgm_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_en  (mode_en),
        .inc      (inc),
        .entry    (entry),
        .active   (active),
        .cfg_open (cfg_open),
        .pc       (pc)
    );

    pgm_region_dec #(.ADDR_W(ADDR_W), .ID_COUNT(ID_COUNT)) u_dec (
        .pc       (pc),
        .cfg_open (cfg_open),
        .region   (region),
        .uidx     (uidx),
        .iidx     (iidx)
    );

    // Staging latch: keeps the low word of each accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '1;
        else if (active && load_vld)
            latch_q <= load_data[WORD_W-1:0];
    end

    // Erase scope from the counter position; erase takes precedence over program.
    always_comb begin
        erase_kind = ER_NONE;
        if (active && erase) begin
            if (region == RG_USER || region == RG_CFGW)
                erase_kind = ER_MAIN;
            else if (pc == CFG_BASE)
                erase_kind = ER_FULL;
        end
    end

    assign wr_en = active && prog && !erase;

    pgm_store #(
        .ADDR_W   (ADDR_W),
        .WORD_W   (WORD_W),
        .ID_COUNT (ID_COUNT),
        .PROT_BIT (PROT_BIT)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .region     (region),
        .uidx       (uidx),
        .iidx       (iidx),
        .wr_en      (wr_en),
        .wr_word    (latch_q),
        .erase_kind (erase_kind),
        .rd_word    (stored_word),
        .prot_on    (prot_on)
    );

    pgm_read_mask #(
        .ADDR_W     (ADDR_W),
        .WORD_W     (WORD_W),
        .BUS_W      (BUS_W),
        .PROT_FLOOR (PROT_FLOOR)
    ) u_mask (
        .region  (region),
        .uidx    (uidx),
        .word    (stored_word),
        .prot_on (prot_on),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/pgm_mode_map_chk.sv
// Property checker for pgm_mode_map, attached by the bind at the end of
// this file. It observes the counter, the gate, the region and the read
// port over time.
// Assumes: reset is synchronous and active low.
module pgm_mode_map_chk
    import pgm_map_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int WORD_W     = 12,
    parameter int BUS_W      = 14,
    parameter int PROT_FLOOR = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              entry,
    input logic              active,
    input logic              inc,
    input logic              erase,
    input logic              cfg_open,
    input logic [ADDR_W-1:0] pc,
    input region_e           region,
    input logic              prot_on,
    input logic [BUS_W-1:0]  rd_data
);

    localparam logic [ADDR_W-1:0] CFG_BASE  = ADDR_W'(1 << (ADDR_W - 1));
    localparam logic [ADDR_W-1:0] USER_LAST = CFG_BASE - 1'b1;
    localparam logic [BUS_W-1:0]  ALL_ONES  = BUS_W'({WORD_W{1'b1}});

    a_r2_entry_loads: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> (pc == '1) && cfg_open);

    a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (active && inc) |=> pc == ADDR_W'($past(pc) + 1'b1));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!entry && !(active && inc)) |=> $stable(pc));

    a_r4_inc_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (active && inc) |=> !cfg_open);

    a_r4_stays_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && !entry) |=> !cfg_open);

    a_r5_void_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_VOID) |-> rd_data == ALL_ONES);

    a_r6_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BUS_W-1:WORD_W] == '0);

    a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_USER && prot_on && pc >= ADDR_W'(PROT_FLOOR) && pc != USER_LAST)
        |-> rd_data == '0);

    a_r9_main_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (active && erase && !inc && (region == RG_USER || region == RG_CFGW))
        |=> rd_data == ALL_ONES);

    a_r10_full_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (active && erase && !inc && pc == CFG_BASE) |=> rd_data == ALL_ONES);

endmodule

bind pgm_mode_map pgm_mode_map_chk #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .BUS_W      (BUS_W),
    .PROT_FLOOR (PROT_FLOOR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .entry    (entry),
    .active   (active),
    .inc      (inc),
    .erase    (erase),
    .cfg_open (cfg_open),
    .pc       (pc),
    .region   (region),
    .prot_on  (prot_on),
    .rd_data  (rd_data)
);

// File: tb/sim_pgm_mode_map.sv
// Self-checking bench: whole-space sweeps against an arithmetic model.
module sim_pgm_mode_map;

    localparam int CLK_PERIOD = 10;
    localparam int SPACE      = 1024;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_en;
    logic        inc;
    logic        load_vld;
    logic [13:0] load_data;
    logic        prog;
    logic        erase;
    logic [9:0]  pc;
    logic [13:0] rd_data;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // Model state
    logic [11:0] m_mem [SPACE];
    logic [11:0] m_cfg;
    logic [11:0] m_latch;
    logic [9:0]  m_pc;
    logic        m_open;
    logic        m_act;

    pgm_mode_map u0 (
        .clk (clk), .rst_n (rst_n), .mode_en (mode_en), .inc (inc),
        .load_vld (load_vld), .load_data (load_data), .prog (prog),
        .erase (erase), .pc (pc), .rd_data (rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [11:0] pat(input int a);
        return 12'((a * 37 + 'h9C3) & 'hFFF);
    endfunction

    // Expected read at the model counter from the requirement text.
    function automatic logic [11:0] exp_read();
        int a = int'(m_pc);
        if (a < 'h200) begin
            if (!m_cfg[3] && a >= 'h40 && a != 'h1FF) return 12'h000;
            return m_mem[a];
        end
        if (a <= 'h204) return m_mem[a];
        if (a == 'h3FF && m_open) return m_cfg;
        return 12'hFFF;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_rd(input string tag);
        chk(tag, {2'b00, rd_data}, {4'h0, exp_read()});
    endtask

    task automatic check_pc(input string tag);
        chk(tag, {6'b0, pc}, {6'b0, m_pc});
    endtask

    // One cycle of strobes; the model applies erase, else program, then load, then step.
    task automatic op(input logic ld, input logic [13:0] d, input logic pr,
                      input logic er, input logic st);
        load_vld = ld; load_data = d; prog = pr; erase = er; inc = st;
        @(posedge clk);
        @(negedge clk);
        load_vld = 1'b0; prog = 1'b0; erase = 1'b0; inc = 1'b0;
        if (m_act) begin
            int a = int'(m_pc);
            if (er) begin
                if (a < 'h200 || (a == 'h3FF && m_open)) begin
                    for (int k = 0; k < 'h200; k++) m_mem[k] = 12'hFFF;
                    m_cfg = 12'hFFF;
                end else if (a == 'h200) begin
                    for (int k = 0; k < SPACE; k++) m_mem[k] = 12'hFFF;
                    m_cfg = 12'hFFF;
                end
            end else if (pr) begin
                if (a <= 'h204) m_mem[a] = m_mem[a] & m_latch;
                else if (a == 'h3FF && m_open) m_cfg = m_cfg & m_latch;
            end
            if (ld) m_latch = d[11:0];
            if (st) begin m_pc = m_pc + 1'b1; m_open = 1'b0; end
        end
    endtask

    task automatic enter(input logic with_inc);
        mode_en = 1'b0;
        op(0, 14'h0, 0, 0, 0);
        m_act = 1'b0;
        mode_en = 1'b1;
        op(0, 14'h0, 0, 0, with_inc);
        m_act = 1'b1; m_pc = 10'h3FF; m_open = 1'b1;
    endtask

    task automatic go_to(input logic [9:0] a);
        while (m_pc != a) op(0, 14'h0, 0, 0, 1);
    endtask

    task automatic sweep_read(input string tag);
        for (int k = 0; k < SPACE; k++) begin
            check_rd(tag);
            op(0, 14'h0, 0, 0, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < SPACE; k++) m_mem[k] = 12'hFFF;
        m_cfg = 12'hFFF; m_latch = 12'hFFF; m_pc = 10'h3FF; m_open = 1'b0; m_act = 1'b0;
        rst_n = 1'b0; mode_en = 1'b0; inc = 1'b0; load_vld = 1'b0;
        load_data = '0; prog = 1'b0; erase = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R2 strobes ignored outside the mode
        check_pc("R1 reset counter");
        check_rd("R1 reset read closed");
        op(0, 14'h0, 0, 0, 1);
        check_pc("R2 inc ignored while mode off");

        // R2 entry: increment in the entry cycle is dropped, config open
        enter(1'b1);
        check_pc("R2 entry counter");
        op(1, 14'h3FFD, 0, 0, 0);
        op(0, 14'h0, 1, 0, 0);
        check_rd("R2 R6 config open and written");

        // R1 blank storage seen through the whole space
        sweep_read("R1 blank readback");
        check_pc("R3 full wrap returns");

        // Write sweep: each program shares its cycle with an increment (R11)
        op(0, 14'h0, 0, 0, 1);
        check_pc("R3 wrap 0x3FF to 0x000");
        for (int a = 0; a < SPACE; a++) begin
            op(1, {2'b11, pat(a)}, 0, 0, 0);
            op(0, 14'h0, 1, 0, 1);
            check_pc("R3 R11 step after program");
        end
        sweep_read("R5 R6 R7 R11 map readback");
        go_to(10'h1FF);
        op(0, 14'h0, 0, 0, 1);
        chk("R3 0x1FF steps to 0x200", {6'b0, pc}, 16'h0200);
        m_pc = 10'h200;

        // R7 load and program in one cycle uses the older latch
        go_to(10'h010);
        op(1, 14'h0F0F, 0, 0, 0);
        op(1, 14'h00FF, 1, 0, 0);
        check_rd("R7 program uses previous latch");
        op(0, 14'h0, 1, 0, 0);
        check_rd("R7 bits only cleared");

        // R4 re-entry reopens config; protect on (bit 3 cleared)
        enter(1'b0);
        check_rd("R4 config visible after re-entry");
        op(1, 14'h0FF5, 0, 0, 0);
        op(0, 14'h0, 1, 0, 0);
        check_rd("R8 protect bit written");
        sweep_read("R8 protected readback");

        // R8 writes to ID and backup under protection; R5 reserved ignored
        go_to(10'h201);
        op(1, 14'h00F0, 1, 0, 0);
        op(0, 14'h0, 1, 0, 0);
        check_rd("R8 id writable while protected");
        go_to(10'h204);
        op(1, 14'h03C3, 0, 0, 0);
        op(0, 14'h0, 1, 0, 0);
        check_rd("R8 backup writable while protected");
        go_to(10'h210);
        op(1, 14'h0000, 0, 0, 0);
        op(0, 14'h0, 1, 0, 0);
        check_rd("R5 reserved write ignored");

        // R11 erase has no effect at other positions
        op(0, 14'h0, 0, 1, 0);
        go_to(10'h201);
        op(0, 14'h0, 0, 1, 0);
        check_rd("R11 erase at id1 ignored");
        go_to(10'h3FF);
        op(0, 14'h0, 0, 1, 0);
        check_rd("R4 erase at closed config ignored");

        // R9 main erase from a protected user address
        go_to(10'h050);
        op(0, 14'h0, 0, 1, 0);
        check_rd("R9 user word erased");
        sweep_read("R9 ids and backup kept");
        enter(1'b0);
        check_rd("R9 config erased");

        // R9 main erase from the open config word
        op(1, 14'h00F0, 0, 0, 0);
        op(0, 14'h0, 1, 0, 0);
        check_rd("R8 config writable");
        op(0, 14'h0, 0, 1, 0);
        check_rd("R9 erase at open config");

        // R11 erase and program together: erase wins
        go_to(10'h005);
        op(1, 14'h0123, 0, 0, 0);
        op(0, 14'h0, 1, 1, 0);
        check_rd("R11 erase beats program");

        // R11 erase with increment acts at the old address
        go_to(10'h1FF);
        op(0, 14'h0, 0, 1, 1);
        check_pc("R11 erase then step");
        check_rd("R11 id0 kept by main erase");

        // R10 full erase at the first id word
        op(0, 14'h0, 0, 1, 0);
        check_rd("R10 id0 erased");
        sweep_read("R10 full erase readback");
        enter(1'b0);
        check_rd("R10 config erased");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule